// File: doc/BRIEF.md
# Processor Wait-State and Sleep-Request Controller

This block is the core-side power control of a simple in-order processor. It keeps the wait-enable bit of the machine state register. While that bit is set, the block stalls the execution pipeline and the clocks keep running. This is the standby state, and an accepted interrupt brings the core back to active execution.

Beyond standby, the block tells an external clock and power manager that the core could have its clocks stopped. It does this by raising a registered sleep request, but only while the core is fully quiet. Fully quiet means no instruction is still in flight (auxiliary-processor operations count too), no cache has a fill or flush running or queued, and the trace FIFO is empty. Wait-enable is cleared by an accepted interrupt, by a debug clear, by reset, or by a software write of zero.

The pipeline, the caches and the trace FIFO live elsewhere. They reach this block only as plain status pins, and the only signal back to the pipeline is a stall. No data stream passes through the block, so it has no valid/ready interface. Every pin is a level-sensitive control or status signal.

Top module: `wait_sleep_ctl`

## Requirements
- R1: Reset (synchronous, `rst_n` low) clears wait-enable, drops sleep request and stall, and drives the power state to active (code 0).
- R2: A write (`msr_wr` high) loads wait-enable from machine-state bit 13 in MSB-first numbering, which is `msr_wdata[18]` for the default 32-bit width. All other data bits have no effect on the outputs.
- R3: While wait-enable is 1, `pipe_stall` is 1 and the state is standby (code 1) or sleep-requested (code 2). Wait-enable keeps its value until an interrupt, a debug clear, a reset or a software write of zero.
- R4: An accepted interrupt (`irq_take`) clears wait-enable at the clock edge where it is sampled. Sleep request and stall are low from the next cycle.
- R5: A debug clear (`dbg_clr`) clears wait-enable and wins over a software write that tries to set it in the same cycle.
- R6: Sleep request is 1 only if wait-enable is set, the in-flight instruction count was zero, and the auxiliary processor was idle.
- R7: A fill or a flush pending on any cache blocks the sleep request.
- R8: A trace FIFO occupancy other than zero blocks the sleep request.
- R9: Sleep request is registered. It goes high one cycle after all conditions hold, and it drops one cycle after any of them fails.
- R10: The power state code is 0 for active, 1 for standby and 2 for sleep requested.
- R11: An accepted interrupt wins over a software write that tries to set wait-enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| msr_wdata | input | XLEN | Machine-state write data |
| msr_wr | input | 1 | Machine-state write strobe |
| dbg_clr | input | 1 | Debug clear of wait-enable |
| irq_take | input | 1 | Interrupt accepted this cycle |
| inflight_cnt | input | CNT_W | Instructions not yet complete |
| apu_busy | input | 1 | Auxiliary-processor operation outstanding |
| cache_fill_pend | input | NCACHE | Fill in progress or queued, one bit per cache |
| cache_flush_pend | input | NCACHE | Flush in progress or queued, one bit per cache |
| trace_cnt | input | TRC_W | Trace FIFO occupancy |
| wait_en | output | 1 | Current wait-enable bit |
| pipe_stall | output | 1 | Halt the execution pipeline |
| sleep_req | output | 1 | Request to the clock/power manager |
| pwr_state | output | 2 | Power state code |

## Verification
The hardest situation to reach is a sleep request that is blocked by exactly one remaining busy source. To get there, the stimulus first sets wait-enable while instructions are still in flight. It then retires the sources one at a time: the auxiliary processor, one cache's fill, the other cache's flush and finally the trace FIFO. After each step the request must stay low. The stimulus also brings a condition back after the request is up, to observe the one-cycle drop. It drives an interrupt and a debug clear in the same cycle as a write that sets the bit, to prove their priority.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_STANDBY = 2'd1,
    PS_SLEEP   = 2'd2
  } pstate_e;
endpackage

// File: rtl/wsc_we_reg.sv
module wsc_we_reg #(
  parameter int XLEN   = 32,
  parameter int WE_POS = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] wdata,
  input  logic            wr,
  input  logic            dbg_clr,
  input  logic            irq_take,
  output logic            we_q,
  output logic            we_next
);
  // machine-state bits are numbered from the MSB
  localparam int LSB_IDX = XLEN - 1 - WE_POS;

  always_comb begin
    we_next = we_q;
    if (wr) we_next = wdata[LSB_IDX];
    if (dbg_clr || irq_take) we_next = 1'b0;
    if (!rst_n) we_next = 1'b0;
  end

  always_ff @(posedge clk) we_q <= we_next;

  AST_IRQ_CLEARS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !we_q); // R4
  AST_DBG_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_clr && wr) |=> !we_q); // R5
  AST_WE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we_q && !wr && !dbg_clr && !irq_take) |=> we_q); // R3
endmodule

// File: rtl/wsc_quiesce.sv
module wsc_quiesce #(
  parameter int CNT_W  = 4,
  parameter int TRC_W  = 5,
  parameter int NCACHE = 2
) (
  input  logic [CNT_W-1:0]  inflight_cnt,
  input  logic              apu_busy,
  input  logic [NCACHE-1:0] fill_pend,
  input  logic [NCACHE-1:0] flush_pend,
  input  logic [TRC_W-1:0]  trace_cnt,
  output logic              quiet
);
  logic [NCACHE-1:0] cache_busy;

  for (genvar g = 0; g < NCACHE; g++) begin : g_cache
    assign cache_busy[g] = fill_pend[g] | flush_pend[g];
  end

  logic core_idle, cache_idle, trace_idle;
  assign core_idle  = (inflight_cnt == '0) && !apu_busy;
  assign cache_idle = (cache_busy == '0);
  assign trace_idle = (trace_cnt == '0);
  assign quiet      = core_idle && cache_idle && trace_idle;
endmodule

// File: rtl/wsc_power.sv
module wsc_power
  import wsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_q,
  input  logic       we_next,
  input  logic       quiet,
  output logic       sleep_q,
  output logic       pipe_stall,
  output logic [1:0] pwr_state
);
  pstate_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) sleep_q <= 1'b0;
    else        sleep_q <= we_next && quiet;
  end

  always_comb begin
    if (!we_q)        st = PS_ACTIVE;
    else if (sleep_q) st = PS_SLEEP;
    else              st = PS_STANDBY;
  end

  assign pwr_state  = st;
  assign pipe_stall = (st != PS_ACTIVE);

  AST_SLEEP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet |=> !sleep_q); // R9
endmodule

// File: rtl/wait_sleep_ctl.sv
module wait_sleep_ctl #(
  parameter int XLEN   = 32,
  parameter int WE_POS = 13,
  parameter int CNT_W  = 4,
  parameter int TRC_W  = 5,
  parameter int NCACHE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   msr_wdata,
  input  logic              msr_wr,
  input  logic              dbg_clr,
  input  logic              irq_take,
  input  logic [CNT_W-1:0]  inflight_cnt,
  input  logic              apu_busy,
  input  logic [NCACHE-1:0] cache_fill_pend,
  input  logic [NCACHE-1:0] cache_flush_pend,
  input  logic [TRC_W-1:0]  trace_cnt,
  output logic              wait_en,
  output logic              pipe_stall,
  output logic              sleep_req,
  output logic [1:0]        pwr_state
);
  logic we_next, quiet;

  wsc_we_reg #(.XLEN(XLEN), .WE_POS(WE_POS)) u_we (
    .clk(clk), .rst_n(rst_n), .wdata(msr_wdata), .wr(msr_wr),
    .dbg_clr(dbg_clr), .irq_take(irq_take), .we_q(wait_en), .we_next(we_next));

  wsc_quiesce #(.CNT_W(CNT_W), .TRC_W(TRC_W), .NCACHE(NCACHE)) u_q (
    .inflight_cnt(inflight_cnt), .apu_busy(apu_busy),
    .fill_pend(cache_fill_pend), .flush_pend(cache_flush_pend),
    .trace_cnt(trace_cnt), .quiet(quiet));

  wsc_power u_pw (
    .clk(clk), .rst_n(rst_n), .we_q(wait_en), .we_next(we_next), .quiet(quiet),
    .sleep_q(sleep_req), .pipe_stall(pipe_stall), .pwr_state(pwr_state));

  AST_SLEEP_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> wait_en); // R6
  AST_SLEEP_CORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> $past(inflight_cnt == '0 && !apu_busy)); // R6
  AST_SLEEP_CACHE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> $past((cache_fill_pend | cache_flush_pend) == '0)); // R7
  AST_SLEEP_TRACE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> $past(trace_cnt == '0)); // R8
  AST_IRQ_ENDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (!sleep_req && !pipe_stall)); // R4
  AST_STALL_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    wait_en |-> pipe_stall); // R3
endmodule

// File: tb/sim_wait_sleep_ctl.sv
module sim_wait_sleep_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WEB = 18;

  typedef struct {
    logic [4:0] v;   // {we, stall, sleep, state[1:0]}
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] msr_wdata = '0;
  logic msr_wr = 0, dbg_clr = 0, irq_take = 0, apu_busy = 0;
  logic [3:0] inflight_cnt = '0;
  logic [1:0] fill = '0, flush = '0;
  logic [4:0] trace_cnt = '0;
  logic wait_en, pipe_stall, sleep_req;
  logic [1:0] pwr_state;

  int checks = 0, errors = 0;
  exp_t q[$];
  logic m_we = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wait_sleep_ctl u0 (
    .clk(clk), .rst_n(rst_n), .msr_wdata(msr_wdata), .msr_wr(msr_wr),
    .dbg_clr(dbg_clr), .irq_take(irq_take), .inflight_cnt(inflight_cnt),
    .apu_busy(apu_busy), .cache_fill_pend(fill), .cache_flush_pend(flush),
    .trace_cnt(trace_cnt), .wait_en(wait_en), .pipe_stall(pipe_stall),
    .sleep_req(sleep_req), .pwr_state(pwr_state));

  task automatic step(input logic wr, input logic [31:0] wd, input logic dbg,
                      input logic irq, input logic [3:0] infl, input logic apu,
                      input logic [1:0] fl, input logic [1:0] fs,
                      input logic [4:0] tr, input string tag);
    exp_t e;
    logic quiet, wn, sn;
    @(negedge clk);
    msr_wr = wr; msr_wdata = wd; dbg_clr = dbg; irq_take = irq;
    inflight_cnt = infl; apu_busy = apu; fill = fl; flush = fs; trace_cnt = tr;
    quiet = (infl == 0) && !apu && (fl == 0) && (fs == 0) && (tr == 0);
    wn = m_we;
    if (wr) wn = wd[WEB];
    if (dbg || irq || !rst_n) wn = 1'b0;
    sn = wn && quiet;
    m_we = wn;
    e.v = {wn, wn, sn, (!wn ? 2'd0 : (sn ? 2'd2 : 2'd1))};
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input logic [3:0] infl, input logic apu, input logic [1:0] fl,
                      input logic [1:0] fs, input logic [4:0] tr, input string tag);
    step(1'b0, 32'h0, 1'b0, 1'b0, infl, apu, fl, fs, tr, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        logic [4:0] act;
        e = q.pop_front();
        act = {wait_en, pipe_stall, sleep_req, pwr_state};
        checks++;
        if (act !== e.v) begin
          errors++;
          $display("FAIL %s actual=%b expected=%b", e.tag, act, e.v);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    checks++;
    if ({wait_en, pipe_stall, sleep_req, pwr_state} !== 5'b0) begin
      errors++;
      $display("FAIL R1 actual=%b expected=00000", {wait_en, pipe_stall, sleep_req, pwr_state});
    end
    rst_n = 1'b1;
    // R2: every bit except the wait-enable bit is ignored
    step(1, 32'hFFFB_FFFF, 0, 0, 0, 0, 0, 0, 0, "R2 other bits");
    // R3/R6: set while instructions in flight -> standby
    step(1, 32'h0004_0000, 0, 0, 3, 0, 0, 0, 0, "R3 set busy");
    idle(3, 0, 0, 0, 0, "R3 hold");
    idle(0, 1, 0, 0, 0, "R6 apu busy");
    idle(0, 0, 2'b10, 0, 0, "R7 fill pending");
    idle(0, 0, 0, 2'b01, 0, "R7 flush pending");
    idle(0, 0, 0, 0, 2, "R8 trace nonempty");
    idle(0, 0, 0, 0, 0, "R9 sleep rises R10");
    idle(0, 0, 0, 0, 0, "R10 sleep held");
    idle(0, 0, 0, 0, 1, "R9 sleep drops");
    idle(0, 0, 0, 0, 0, "R9 sleep again");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R4 irq wakes");
    idle(0, 0, 0, 0, 0, "R4 stays active");
    step(1, 32'h0004_0000, 0, 1, 0, 0, 0, 0, 0, "R11 irq beats write");
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, "R9 immediate sleep");
    step(1, 32'h0004_0000, 1, 0, 0, 0, 0, 0, 0, "R5 dbg beats write");
    step(1, 32'h0004_0000, 0, 0, 5, 0, 0, 0, 0, "R3 set again");
    step(1, 32'hFFFB_FFFF, 0, 0, 5, 0, 0, 0, 0, "R3 sw clear");
    step(1, 32'h0004_0000, 0, 0, 0, 0, 0, 0, 0, "R2 set quiet");
    @(negedge clk); rst_n = 1'b0;
    idle(0, 0, 0, 0, 0, "R1 reset mid run");
    @(negedge clk); rst_n = 1'b1;
    idle(0, 0, 0, 0, 0, "R1 after reset");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule